// File: doc/BRIEF.md
# Reversible synchronous binary counter

The block is a small binary counter that steps up or down by one on each rising clock edge while its active-low enable is asserted. A single direction input picks the sense of the count, and the count wraps at both ends of its range. An active-low parallel load presets the counter from the data inputs at once, without waiting for a clock edge, and overrides counting.

Two outputs let several counters be joined into a wider one. A terminal flag is high when the count sits at the last value in the selected direction: all ones when counting up, zero when counting down. An active-low ripple-clock output pulses low during the low half of the clock under the same condition, provided counting is enabled. Feeding that pulse into the clock of a following stage, whose enable is tied active, builds a longer counter.

Top module: `updown_counter`

## Requirements
- R1: With `load_ni` high, `en_ni` low and `dir_i` = 0 (up), each rising clock edge adds one to `q_o`, wrapping from 15 to 0, with all bits changing at that edge.
- R2: With `load_ni` high, `en_ni` low and `dir_i` = 1 (down), each rising clock edge subtracts one from `q_o`, wrapping from 0 to 15.
- R3: With `load_ni` high and `en_ni` high, `q_o` keeps its value across clock edges.
- R4: A change on `en_ni` or `dir_i` between clock edges leaves `q_o` unchanged until the next rising edge.
- R5: While `load_ni` is low, `q_o` equals `data_i` with no clock edge needed, follows later changes of `data_i`, and overrides counting; after `load_ni` returns high, counting resumes from the last loaded value.
- R6: `term_o` is high exactly when `q_o` is 15 with `dir_i` = 0, or 0 with `dir_i` = 1, and follows a direction change at once.
- R7: `rco_no` is low exactly when `term_o` is high, `en_ni` is low and `clk_i` is low; otherwise it is high.
- R8: While `rst_ni` is low the count is 0.
- R9: A second counter clocked by `rco_no` of the first, with its enable held low and the same direction, forms the upper digit of a counter twice as wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; counting occurs on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset to zero |
| en_ni | input | 1 | Active-low count enable |
| dir_i | input | 1 | Count direction: 0 up, 1 down |
| load_ni | input | 1 | Active-low asynchronous parallel load |
| data_i | input | WIDTH | Preset value |
| q_o | output | WIDTH | Current count |
| term_o | output | 1 | High at the terminal value for the selected direction |
| rco_no | output | 1 | Active-low cascade pulse during the clock-low phase |

## Verification
The clocked checks take for granted that enable, direction, load and data change only while the clock is high and away from its rising edge, and that any load pulse spans at least one rising edge, so the stored value has caught the latest data before load is released. The stimulus meets this by driving every input a few nanoseconds after a rising edge and holding it for a whole cycle, including the directed step that changes the data twice during one load. Driving nothing in the clock-low phase also keeps the ripple-clock pulse free of glitches, which the cascaded second stage depends on.

// File: rtl/updown_pkg.sv
package updown_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/updown_core.sv
module updown_core
  import updown_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             en_ni,
  input  dir_e             dir_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_step;

  always_comb begin
    if (dir_i == DIR_DOWN) cnt_step = cnt_q - 1'b1;
    else                   cnt_step = cnt_q + 1'b1;
  end

  // load acts as a second asynchronous control, below reset
  always_ff @(posedge clk_i or negedge rst_ni or negedge load_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!load_ni) cnt_q <= data_i;
    else if (!en_ni)   cnt_q <= cnt_step;
  end

  // during load the preset shows through without waiting for the register
  assign q_o = load_ni ? cnt_q : data_i;

  a_r1_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_ni && dir_i == DIR_UP) |=> (!load_ni || cnt_q == $past(cnt_q) + 1'b1));

  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_ni && dir_i == DIR_DOWN) |=> (!load_ni || cnt_q == $past(cnt_q) - 1'b1));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_ni) |=> (!load_ni || $stable(cnt_q)));

  a_r5_load_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (cnt_q == $past(data_i)));

endmodule

// File: rtl/updown_term.sv
module updown_term
  import updown_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             en_ni,
  input  dir_e             dir_i,
  input  logic [WIDTH-1:0] q_i,
  output logic             term_o,
  output logic             rco_no
);

  localparam logic [WIDTH-1:0] CntTop = {WIDTH{1'b1}};

  logic at_top;
  logic at_bottom;

  assign at_top    = (q_i == CntTop);
  assign at_bottom = (q_i == '0);

  always_comb begin
    if (dir_i == DIR_DOWN) term_o = at_bottom;
    else                   term_o = at_top;
  end

  // pulse confined to the clock-low half; rises with the next clock edge
  assign rco_no = ~(term_o & ~en_ni & ~clk_i);

endmodule

// File: rtl/updown_counter.sv
module updown_counter
  import updown_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             dir_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o,
  output logic             term_o,
  output logic             rco_no
);

  dir_e dir;
  assign dir = dir_e'(dir_i);

  updown_core #(.WIDTH(WIDTH)) core_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_ni (load_ni),
    .en_ni   (en_ni),
    .dir_i   (dir),
    .data_i  (data_i),
    .q_o     (q_o)
  );

  updown_term #(.WIDTH(WIDTH)) term_i (
    .clk_i  (clk_i),
    .en_ni  (en_ni),
    .dir_i  (dir),
    .q_i    (q_o),
    .term_o (term_o),
    .rco_no (rco_no)
  );

  // flag at the top while counting up must be followed by wrap to zero
  a_r6_term_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o && !dir_i && load_ni && !en_ni) |=> (!load_ni || q_o == '0));

endmodule

// File: tb/updown_counter_tb.sv
`timescale 1ns/1ps
module updown_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_n;
  logic       dir_s;
  logic       load_n;
  logic [3:0] data;
  logic [3:0] q_lo, q_hi;
  logic       term_lo, term_hi;
  logic       rco_lo, rco_hi;

  int checks = 0;
  int failures = 0;

  logic [3:0] m_q;
  logic [3:0] m_hi;

  always #10 clk = ~clk;

  updown_counter #(.WIDTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .dir_i(dir_s), .load_ni(load_n),
    .data_i(data), .q_o(q_lo), .term_o(term_lo), .rco_no(rco_lo)
  );

  // upper digit: clocked by the lower stage's ripple pulse, always enabled
  updown_counter #(.WIDTH(4)) chain_hi_i (
    .clk_i(rco_lo), .rst_ni(rst_n), .en_ni(1'b0), .dir_i(dir_s), .load_ni(1'b1),
    .data_i(4'd0), .q_o(q_hi), .term_o(term_hi), .rco_no(rco_hi)
  );

  function automatic logic exp_term(input logic [3:0] v, input logic d);
    return d ? (v == 4'd0) : (v == 4'd15);
  endfunction

  function automatic logic [3:0] stepped(input logic [3:0] v, input logic d);
    return d ? v - 4'd1 : v + 4'd1;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive at clock-high time, verify in high and low phases, advance model at the edge
  task automatic cyc(input logic en, input logic d, input logic ld, input logic [3:0] dv);
    logic [3:0] vis;
    logic       t;
    en_n = en; dir_s = d; load_n = ld; data = dv;
    #1;
    vis = ld ? m_q : dv;
    if (ld) chk(q_lo == vis, "R4", q_lo, vis);
    else    chk(q_lo == vis, "R5", q_lo, vis);
    chk(rco_lo == 1'b1, "R7", rco_lo, 1);
    @(negedge clk); #3;
    t = exp_term(vis, d);
    if (!ld)     chk(q_lo == vis, "R5", q_lo, vis);
    else if (en) chk(q_lo == vis, "R3", q_lo, vis);
    else if (d)  chk(q_lo == vis, "R2", q_lo, vis);
    else         chk(q_lo == vis, "R1", q_lo, vis);
    chk(term_lo == t, "R6", term_lo, t);
    chk(rco_lo == !(t && !en), "R7", rco_lo, !(t && !en));
    chk(q_hi == m_hi, "R9", q_hi, m_hi);
    @(posedge clk);
    if (t && !en) m_hi = stepped(m_hi, d);
    if (!ld)      m_q = dv;
    else if (!en) m_q = stepped(m_q, d);
    #3;
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en_n = 1'b1; dir_s = 1'b0; load_n = 1'b1; data = 4'd0;
    m_q = 4'd0; m_hi = 4'd0;
    repeat (2) @(posedge clk);
    #3;
    chk(q_lo == 4'd0, "R8", q_lo, 0);
    chk(q_hi == 4'd0, "R8", q_hi, 0);
    chk(term_lo == 1'b0, "R6", term_lo, 0);
    rst_n = 1'b1;

    // R1 up wrap 13 -> 14 -> 15 -> 0
    cyc(1'b1, 1'b0, 1'b0, 4'd13);
    repeat (4) cyc(1'b0, 1'b0, 1'b1, 4'd0);

    // R6 direction change while sitting at 15
    cyc(1'b1, 1'b0, 1'b0, 4'd15);
    cyc(1'b1, 1'b1, 1'b1, 4'd0);
    cyc(1'b1, 1'b0, 1'b1, 4'd0);
    cyc(1'b0, 1'b1, 1'b1, 4'd0);

    // R2 down wrap 1 -> 0 -> 15, then direction change at 0
    cyc(1'b1, 1'b1, 1'b0, 4'd1);
    repeat (3) cyc(1'b0, 1'b1, 1'b1, 4'd0);
    cyc(1'b1, 1'b1, 1'b0, 4'd0);
    cyc(1'b1, 1'b0, 1'b1, 4'd0);
    cyc(1'b1, 1'b1, 1'b1, 4'd0);
    cyc(1'b0, 1'b1, 1'b1, 4'd0);

    // R3 hold over several edges
    repeat (3) cyc(1'b1, 1'b0, 1'b1, 4'd0);

    // R5 load tracks data within one clock-high phase, no edge in between
    load_n = 1'b0; data = 4'd5;
    #1 chk(q_lo == 4'd5, "R5", q_lo, 5);
    data = 4'd9;
    #1 chk(q_lo == 4'd9, "R5", q_lo, 9);
    cyc(1'b0, 1'b0, 1'b0, 4'd9);
    cyc(1'b0, 1'b0, 1'b1, 4'd0);

    // R4 en/dir toggled between edges do not disturb the stored count
    en_n = 1'b0; dir_s = 1'b1;
    #1 chk(q_lo == m_q, "R4", q_lo, m_q);
    en_n = 1'b1; dir_s = 1'b0;
    #1 chk(q_lo == m_q, "R4", q_lo, m_q);
    cyc(1'b1, 1'b0, 1'b1, 4'd0);

    // R9 long up run carries into the upper digit, then down run borrows
    repeat (40) cyc(1'b0, 1'b0, 1'b1, 4'd0);
    repeat (40) cyc(1'b0, 1'b1, 1'b1, 4'd0);

    for (int i = 0; i < 1500; i++) begin
      logic en, d, ld;
      en = ($urandom % 4) == 0;
      d  = ($urandom % 8) < 3 ? ~dir_s : dir_s;
      ld = ($urandom % 10) != 0;
      cyc(en, d, ld, 4'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule